// File: doc/BRIEF.md
# Integer ALU with Condition Flag Generation

This block is the data-processing heart of a small 32-bit integer core. It takes two operands and a four-bit operation code. It returns the result, a strobe that says whether that result should be written back, and the next value of the four condition flags: negative, zero, carry and overflow. The datapath is purely combinational. A flag register wraps it. The register feeds the current carry and flags back into the datapath and loads the next flags on every clock edge.

Each operation class has its own rule for the flags. Arithmetic operations update all four flags. Subtraction is formed as the first operand plus the inverted second operand plus a carry in, so a set carry after a subtract means that no borrow occurred. Bitwise operations, multiply and move touch only negative and zero, and they keep the stored carry and overflow. The three comparison-style operations never produce a write. They always update the flags, whatever the set-flags input says. Every other operation changes the flags only when set-flags is high.

Top module: `alu_flagcore`

## Requirements
- R1: Add (op 0) yields A+B with carry in 0. Add-with-carry (op 1) yields A+B+C, where C is the stored carry. For both, C becomes the carry out of bit 31.
- R2: Subtract (op 2) yields A+~B+1. Subtract-with-carry (op 3) yields A+~B+C, which equals A−B−(1−C). For both, C is set exactly when no borrow occurs, so 2−1 gives 1 with C=1 and 0−1 gives C=0.
- R3: On arithmetic ops (0..6), V is set when the signed result leaves the 32-bit signed range. For example, 0x80000000+0xFFFFFFFF gives 0x7FFFFFFF with V=1.
- R4: Whenever the flags are updated, N equals bit 31 of the computed value and Z is set exactly when all 32 bits are zero. The flag vector is ordered {N,Z,C,V}, with N in bit 3 and V in bit 0.
- R5: The bitwise ops are AND (7), XOR (8), OR (9), bit-clear A&~B (10), move-not ~B (11) and test (12, which evaluates A&B). They update only N and Z, and they keep C and V unchanged.
- R6: Multiply (op 13) yields the low 32 bits of A*B, updates only N and Z, and keeps C and V.
- R7: Compare (op 5, evaluates A−B), compare-negative (op 6, evaluates A+B) and test (op 12) never assert the write strobe. They update the flags even when set-flags is low.
- R8: Negate (op 4) yields 0−B with a full NZCV update. Negating 0 gives Z=1 and C=1.
- R9: When set-flags is low, the next flags equal the stored flags for every op except 5, 6 and 12.
- R10: Move (op 14) yields B with the write strobe set. With set-flags high it updates N and Z only.
- R11: Op 15 is reserved. It writes nothing and leaves the flags unchanged.
- R12: The flag output loads the next flags on every rising clock edge, and an active-low reset clears it to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| opa_i | input | 32 | First operand A |
| opb_i | input | 32 | Second operand B |
| setf_i | input | 1 | Set-flags enable |
| res_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Result write strobe |
| flags_next_o | output | 4 | Next flags {N,Z,C,V} |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The bench targets the carry sense of subtraction and checks that 2−1 and 0−0 set carry while 0−1 clears it. A design that used a true borrow would invert all three. It drives subtract-with-carry with the stored carry both set and clear, and it checks overflow at both signed extremes, including negation of 0x80000000, where an overflow term built on the raw B operand rather than the inverted one gives the wrong V. It also interleaves bitwise, multiply and move ops after an arithmetic op that has set C and V. A design that cleared those flags, or that let set-flags low gate compare and test, would show a mismatch in the next stored flags.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int ALU_W  = 32;
  localparam int OP_W   = 4;
  localparam int FLAG_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_NEG = 4'd4,
    OP_CMP = 4'd5,
    OP_CMN = 4'd6,
    OP_AND = 4'd7,
    OP_EOR = 4'd8,
    OP_ORR = 4'd9,
    OP_BIC = 4'd10,
    OP_MVN = 4'd11,
    OP_TST = 4'd12,
    OP_MUL = 4'd13,
    OP_MOV = 4'd14,
    OP_RSV = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  function automatic logic is_arith(alu_op_e op);
    return (op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP, OP_CMN});
  endfunction

  function automatic logic is_probe(alu_op_e op);
    return (op inside {OP_CMP, OP_CMN, OP_TST});
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] ext_add(logic [WIDTH-1:0] x,
                                             logic [WIDTH-1:0] y,
                                             logic             ci);
    return {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, ci};
  endfunction

  function automatic logic sgn_ovf(logic xs, logic ys, logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [WIDTH-1:0] x_sel, y_sel;
  logic             cin_sel;
  logic [WIDTH:0]   wide;

  always_comb begin
    x_sel   = a;
    y_sel   = b;
    cin_sel = 1'b0;
    unique case (op)
      OP_ADD, OP_CMN: begin y_sel = b;  cin_sel = 1'b0; end
      OP_ADC:         begin y_sel = b;  cin_sel = c_in; end
      OP_SUB, OP_CMP: begin y_sel = ~b; cin_sel = 1'b1; end
      OP_SBC:         begin y_sel = ~b; cin_sel = c_in; end
      OP_NEG:         begin x_sel = '0; y_sel = ~b; cin_sel = 1'b1; end
      default:        begin x_sel = a;  y_sel = b;  cin_sel = 1'b0; end
    endcase
  end

  assign wide  = ext_add(x_sel, y_sel, cin_sel);
  assign sum   = wide[MSB:0];
  assign c_out = wide[WIDTH];
  assign v_out = sgn_ovf(x_sel[MSB], y_sel[MSB], wide[MSB]);

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);

  function automatic logic [WIDTH-1:0] mul_lo(logic [WIDTH-1:0] x,
                                              logic [WIDTH-1:0] y);
    logic [WIDTH-1:0] p;
    p = x * y;
    return p;
  endfunction

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = a & b;
      OP_EOR:         res = a ^ b;
      OP_ORR:         res = a | b;
      OP_BIC:         res = a & ~b;
      OP_MVN:         res = ~b;
      OP_MUL:         res = mul_lo(a, b);
      OP_MOV:         res = b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flagsel.sv
module alu_flagsel
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W
) (
  input  alu_op_e          op,
  input  logic             setf,
  input  logic [WIDTH-1:0] arith_res,
  input  logic             arith_c,
  input  logic             arith_v,
  input  logic [WIDTH-1:0] bit_res,
  input  nzcv_t            flags_cur,
  output logic [WIDTH-1:0] res,
  output logic             wr_en,
  output nzcv_t            flags_nxt,
  output logic             upd_nz,
  output logic             upd_cv
);

  logic arith, probe, valid_op;

  assign arith    = is_arith(op);
  assign probe    = is_probe(op);
  assign valid_op = (op != OP_RSV);

  assign res    = arith ? arith_res : bit_res;
  assign wr_en  = valid_op && !probe;
  assign upd_nz = valid_op && (setf || probe);
  assign upd_cv = upd_nz && arith;

  always_comb begin
    flags_nxt = flags_cur;
    if (upd_nz) begin
      flags_nxt.n = res[WIDTH-1];
      flags_nxt.z = (res == '0);
    end
    if (upd_cv) begin
      flags_nxt.c = arith_c;
      flags_nxt.v = arith_v;
    end
  end

endmodule

// File: rtl/alu_flagcore.sv
module alu_flagcore
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WIDTH-1:0]  opa_i,
  input  logic [WIDTH-1:0]  opb_i,
  input  logic              setf_i,
  output logic [WIDTH-1:0]  res_o,
  output logic              wr_en_o,
  output logic [FLAG_W-1:0] flags_next_o,
  output logic [FLAG_W-1:0] flags_o
);

  alu_op_e          op;
  nzcv_t            flags_q, flags_d;
  logic [WIDTH-1:0] arith_res, bit_res;
  logic             arith_c, arith_v;
  logic             upd_nz, upd_cv;

  assign op = alu_op_e'(op_i);

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .op    (op),
    .a     (opa_i),
    .b     (opb_i),
    .c_in  (flags_q.c),
    .sum   (arith_res),
    .c_out (arith_c),
    .v_out (arith_v)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .op  (op),
    .a   (opa_i),
    .b   (opb_i),
    .res (bit_res)
  );

  alu_flagsel #(.WIDTH(WIDTH)) u_flagsel (
    .op        (op),
    .setf      (setf_i),
    .arith_res (arith_res),
    .arith_c   (arith_c),
    .arith_v   (arith_v),
    .bit_res   (bit_res),
    .flags_cur (flags_q),
    .res       (res_o),
    .wr_en     (wr_en_o),
    .flags_nxt (flags_d),
    .upd_nz    (upd_nz),
    .upd_cv    (upd_cv)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_next_o = flags_d;
  assign flags_o      = flags_q;

endmodule

// File: rtl/alu_flagcore_chk.sv
module alu_flagcore_chk
  import alu_pkg::*;
#(
  parameter int WIDTH = ALU_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [OP_W-1:0]   op_i,
  input logic              setf_i,
  input logic [WIDTH-1:0]  res_o,
  input logic              wr_en_o,
  input logic [FLAG_W-1:0] flags_next_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic              upd_nz,
  input logic              upd_cv
);

  logic probe_op, bit_op, keep_op;
  assign probe_op = (op_i == 4'd5) || (op_i == 4'd6) || (op_i == 4'd12);
  assign bit_op   = (op_i >= 4'd7) && (op_i <= 4'd14);
  assign keep_op  = (!setf_i && !probe_op) || (op_i == 4'd15);

  p_probe_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_op |-> !wr_en_o);

  p_probe_update_r7: assert property (@(posedge clk) disable iff (!rst_n)
    probe_op |-> upd_nz);

  p_hold_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
    keep_op |-> (flags_next_o == flags_o));

  p_keep_cv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_op |-> (flags_next_o[1:0] == flags_o[1:0] && !upd_cv));

  p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_nz |-> (flags_next_o[2] == (res_o == '0) && flags_next_o[3] == res_o[WIDTH-1]));

  p_reserved_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 4'd15) |-> !wr_en_o);

  p_flag_reg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (flags_o == $past(flags_next_o)));

endmodule

bind alu_flagcore alu_flagcore_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .op_i         (op_i),
  .setf_i       (setf_i),
  .res_o        (res_o),
  .wr_en_o      (wr_en_o),
  .flags_next_o (flags_next_o),
  .flags_o      (flags_o),
  .upd_nz       (upd_nz),
  .upd_cv       (upd_cv)
);

// File: tb/alu_flagcore_test.sv
module alu_flagcore_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic        setf_i = 1'b0;
  logic [31:0] res_o;
  logic        wr_en_o;
  logic [3:0]  flags_next_o, flags_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] mflags = 4'b0000;

  always #5 clk = ~clk;

  alu_flagcore uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .opb_i(opb_i),
    .setf_i(setf_i), .res_o(res_o), .wr_en_o(wr_en_o),
    .flags_next_o(flags_next_o), .flags_o(flags_o)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0, 4'd1:  return "R1";
      4'd2, 4'd3:  return "R2";
      4'd4:        return "R8";
      4'd5, 4'd6, 4'd12: return "R7";
      4'd13:       return "R6";
      4'd14:       return "R10";
      4'd15:       return "R11";
      default:     return "R5";
    endcase
  endfunction

  // Reference model written with signed/unsigned 64-bit arithmetic.
  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic sf, input logic [3:0] fl,
                       output logic [31:0] r, output logic we, output logic [3:0] nf);
    longint ua, ub, sa, sb, ur, sr;
    logic c, v, full, touch;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    c = fl[1]; v = fl[0]; full = 1'b0; r = '0;
    case (op)
      4'd0, 4'd6: begin ur = ua + ub; sr = sa + sb; full = 1; end
      4'd1: begin ur = ua + ub + longint'(fl[1]); sr = sa + sb + longint'(fl[1]); full = 1; end
      4'd2, 4'd5: begin ur = ua - ub; sr = sa - sb; full = 1; end
      4'd3: begin ur = ua - ub - longint'(!fl[1]); sr = sa - sb - longint'(!fl[1]); full = 1; end
      4'd4: begin ur = 0 - ub; sr = 0 - sb; full = 1; end
      default: begin ur = 0; sr = 0; end
    endcase
    if (full) begin
      r = ur[31:0];
      if (op inside {4'd0, 4'd1, 4'd6}) c = (ur > 64'hFFFF_FFFF);
      else c = (ur >= 0);
      v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    end else begin
      case (op)
        4'd7, 4'd12: r = a & b;
        4'd8:  r = a ^ b;
        4'd9:  r = a | b;
        4'd10: r = a & ~b;
        4'd11: r = ~b;
        4'd13: r = 32'(ua * ub);
        4'd14: r = b;
        default: r = '0;
      endcase
    end
    we = !(op inside {4'd5, 4'd6, 4'd12, 4'd15});
    touch = (op != 4'd15) && (sf || op inside {4'd5, 4'd6, 4'd12});
    nf = fl;
    if (touch) nf = {r[31], r == 0, full ? c : fl[1], full ? v : fl[0]};
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sf);
    logic [31:0] er; logic ew; logic [3:0] ef;
    @(negedge clk);
    op_i = op; opa_i = a; opb_i = b; setf_i = sf;
    model(op, a, b, sf, mflags, er, ew, ef);
    #2;
    chk(wr_en_o == ew, req_of(op), "write strobe", 32'(wr_en_o), 32'(ew));
    if (ew) chk(res_o == er, req_of(op), "result", res_o, er);
    if (sf || op inside {4'd5, 4'd6, 4'd12})
      chk(flags_next_o == ef, op inside {4'd0,4'd1,4'd2,4'd3,4'd4} ? "R3" : "R4",
          "next flags", 32'(flags_next_o), 32'(ef));
    else
      chk(flags_next_o == ef, "R9", "held flags", 32'(flags_next_o), 32'(ef));
    @(posedge clk); #1;
    chk(flags_o == ef, "R12", "stored flags", 32'(flags_o), 32'(ef));
    mflags = ef;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  initial begin
    void'($urandom(32'd1357));
    #3;
    chk(flags_o == 4'b0000, "R12", "reset flags", 32'(flags_o), 32'h0);
    #20 rst_n = 1'b1;
    // Directed corners
    step(4'd2, 32'd2, 32'd1, 1'b1);                       // R2: 2-1 => C=1
    step(4'd2, 32'd0, 32'd1, 1'b1);                       // R2: 0-1 => C=0
    step(4'd0, 32'h8000_0000, 32'hFFFF_FFFF, 1'b1);       // R3: V=1
    step(4'd1, 32'hFFFF_FFFE, 32'd1, 1'b1);               // R1: +C=1 => 0, Z,C
    step(4'd3, 32'd5, 32'd5, 1'b1);                       // R2: SBC with C=1
    step(4'd2, 32'd0, 32'd1, 1'b1);                       // clear C
    step(4'd3, 32'd5, 32'd5, 1'b1);                       // R2: SBC with C=0 => -1
    step(4'd4, 32'd0, 32'd0, 1'b1);                       // R8: neg 0 => Z,C
    step(4'd4, 32'd0, 32'h8000_0000, 1'b1);               // R8/R3: V=1
    step(4'd0, 32'h7FFF_FFFF, 32'd1, 1'b1);               // R3: V=1 set for keep tests
    step(4'd7, 32'hF0F0_0000, 32'h0F0F_0000, 1'b1);       // R5: Z, C/V kept
    step(4'd11, 32'd0, 32'h0000_0001, 1'b1);              // R5: move-not
    step(4'd13, 32'h0001_0001, 32'h0001_0001, 1'b1);      // R6
    step(4'd5, 32'd7, 32'd7, 1'b0);                       // R7: cmp with setf low
    step(4'd6, 32'h8000_0000, 32'h8000_0000, 1'b0);       // R7: cmn
    step(4'd12, 32'hFF, 32'h100, 1'b0);                   // R7: test
    step(4'd0, 32'hFFFF_FFFF, 32'd1, 1'b0);               // R9: no update
    step(4'd14, 32'd0, 32'h8000_0000, 1'b1);              // R10
    step(4'd15, 32'd0, 32'd0, 1'b1);                      // R11
    for (int i = 0; i < 3000; i++)
      step(4'($urandom_range(0, 15)), pick(), pick(), 1'($urandom_range(0, 3) != 0));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule